// File: doc/BRIEF.md
# Clock Phase Offset Measurement Controller

This block measures how far apart two clock domains sit in phase, for example a recovered receive clock and a transmit interface clock. It runs on a measurement clock whose phase an external PLL can shift by one step on request. Each target clock is sampled by that measurement clock. The controller steps the measurement phase through one whole target period, one step at a time. For each target it records the step at which the sampled level first changes from low to high.

After a complete sweep the block publishes both raw step offsets and their absolute difference. The absolute difference is the inter-domain latency in units of the phase-step resolution. If either target never shows a rising transition during the sweep, an error flag is raised instead.

The caller pulses `start` to begin a sweep. It then waits for `res_valid` or `err`. The number of phase steps per period is a parameter. More steps give a finer result but make a sweep longer.

Top module: `phase_skew_meter`

## Requirements
- R1: During and right after reset, `step_req`, `res_valid` and `err` are low, and `cur_step`, `res_off_a`, `res_off_b` and `res_diff` are zero.
- R2: A phase step is requested by a `step_req` pulse that lasts exactly one cycle. No further `step_req` is issued until `step_done` is seen. A `step_done` that arrives while no step is outstanding (for example while idle) is ignored, so `cur_step` does not change.
- R3: `cur_step` advances by one on each accepted `step_done` and wraps from STEPS-1 to 0. A sweep issues exactly STEPS step requests, so after a sweep `cur_step` is back at its starting value.
- R4: Each target level passes through a chain of at least two flops clocked by the measurement clock. A sample is taken only after at least SETTLE_CYC cycles, where SETTLE_CYC is no less than the chain depth, have passed since the step was acknowledged or the sweep started.
- R5: A sweep samples STEPS+1 positions: the start step, each following step, and the start step again. A target's offset is the step number of the first sample, in that order, whose level is 1 while the previous sample's level is 0. Later rising transitions in the same sweep do not change the offset.
- R6: When both targets show a transition, `res_off_a` and `res_off_b` take the two offsets and `res_diff` takes their absolute difference. `res_valid` pulses high for exactly one cycle.
- R7: If either target shows no transition, `err` goes high and stays high, `res_valid` stays low, and the result outputs keep their previous values. `err` is cleared when the next sweep is started.
- R8: A `start` pulse during a sweep in progress is ignored. The sweep keeps its sample count and step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock (phase-shiftable) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| step_done | input | 1 | PLL acknowledges a phase step |
| tgt_a | input | 1 | First target clock, raw |
| tgt_b | input | 1 | Second target clock, raw |
| step_req | output | 1 | One-cycle request for one phase step |
| cur_step | output | $clog2(STEPS) | Current measurement phase step |
| res_valid | output | 1 | One-cycle pulse: new result published |
| res_off_a | output | $clog2(STEPS) | Rising-transition step of tgt_a |
| res_off_b | output | $clog2(STEPS) | Rising-transition step of tgt_b |
| res_diff | output | $clog2(STEPS) | Absolute offset difference |
| err | output | 1 | Last sweep found no transition on a target |

## Verification
The bench builds the block with STEPS=8, a two-flop chain and a settle delay of 3. With only eight steps, every pair of rising-edge positions for two half-duty targets can be swept, which covers all 64 offset pairs and both signs of the difference.

The PLL model in the bench changes the target levels at the same moment it acknowledges a step, and its acknowledge latency varies from one to four cycles. This stresses the settle rule. Extra target patterns cover several specific cases:
- two rising edges in one period, including one found only on the wrap-around sample;
- constant targets that must raise the error;
- stray acknowledges while idle;
- a second start issued mid-sweep.

// File: rtl/phsk_pkg.sv
package phsk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_STEP   = 3'd3,
    ST_WAIT   = 3'd4,
    ST_FINISH = 3'd5
  } sweep_state_e;

  localparam int NUM_DOMAINS = 2;
endpackage

// File: rtl/phsk_sync.sv
module phsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[DEPTH-1];
endmodule

// File: rtl/phsk_edge_find.sv
module phsk_edge_find #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample_en,
  input  logic          level,
  input  logic [SW-1:0] step,
  output logic          found_o,
  output logic [SW-1:0] offset_o
);
  logic          found_q, found_d;
  logic          prev_q, prev_d;
  logic          have_q, have_d;
  logic [SW-1:0] off_q, off_d;
  logic          rise;

  assign rise = sample_en && have_q && !prev_q && level && !found_q;

  always_comb begin
    found_d = found_q;
    prev_d  = prev_q;
    have_d  = have_q;
    off_d   = off_q;
    if (clear) begin
      found_d = 1'b0;
      have_d  = 1'b0;
    end else if (sample_en) begin
      prev_d = level;
      have_d = 1'b1;
      if (rise) begin
        found_d = 1'b1;
        off_d   = step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
      off_q   <= '0;
    end else begin
      found_q <= found_d;
      prev_q  <= prev_d;
      have_q  <= have_d;
      if (rise) off_q <= off_d;
    end
  end

  assign found_o  = found_q;
  assign offset_o = off_q;

  // R5
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_o) |-> ($past(sample_en) && $past(level)));

  // R5
  first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && $past(found_o)) |-> $stable(offset_o));
endmodule

// File: rtl/phsk_sweep_ctrl.sv
module phsk_sweep_ctrl
  import phsk_pkg::*;
#(
  parameter int STEPS      = 16,
  parameter int SETTLE_CYC = 4,
  localparam int SW        = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step_done,
  output logic          step_req_o,
  output logic [SW-1:0] cur_step_o,
  output logic          clear_o,
  output logic          sample_en_o,
  output logic          finish_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam int NW = $clog2(STEPS + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
  localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);
  localparam logic [NW-1:0] SAMPLE_END = NW'(STEPS);

  sweep_state_e  state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic [CW-1:0] settle_q, settle_d;
  logic [NW-1:0] samp_q, samp_d;
  logic          step_en;

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    settle_d    = settle_q;
    samp_d      = samp_q;
    step_en     = 1'b0;
    clear_o     = 1'b0;
    sample_en_o = 1'b0;
    step_req_o  = 1'b0;
    finish_o    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          clear_o  = 1'b1;
          settle_d = '0;
          samp_d   = '0;
          state_d  = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settle_q == SETTLE_END) state_d = ST_SAMPLE;
        else                        settle_d = settle_q + 1'b1;
      end
      ST_SAMPLE: begin
        sample_en_o = 1'b1;
        if (samp_q == SAMPLE_END) begin
          state_d = ST_FINISH;
        end else begin
          samp_d  = samp_q + 1'b1;
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        step_req_o = 1'b1;
        state_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (step_done) begin
          step_en  = 1'b1;
          step_d   = (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
          settle_d = '0;
          state_d  = ST_SETTLE;
        end
      end
      ST_FINISH: begin
        finish_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      settle_q <= '0;
      samp_q   <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
      samp_q   <= samp_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign cur_step_o = step_q;

  // checker state: cycles since the last acknowledged step or sweep start
  logic [CW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= '0;
    else if (clear_o || (state_q == ST_WAIT && step_done))
      since_q <= '0;
    else if (since_q != CW'(SETTLE_CYC))
      since_q <= since_q + 1'b1;
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |=> !step_req_o);

  // R3
  step_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step_o != $past(cur_step_o)) |-> $past(step_done));

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step_o != $past(cur_step_o)) |->
      (cur_step_o == (($past(cur_step_o) == LAST_STEP) ? '0 : $past(cur_step_o) + 1'b1)));

  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> (since_q >= CW'(SETTLE_CYC)));
endmodule

// File: rtl/phase_skew_meter.sv
module phase_skew_meter
  import phsk_pkg::*;
#(
  parameter int STEPS       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4,
  localparam int SW         = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step_done,
  input  logic          tgt_a,
  input  logic          tgt_b,
  output logic          step_req,
  output logic [SW-1:0] cur_step,
  output logic          res_valid,
  output logic [SW-1:0] res_off_a,
  output logic [SW-1:0] res_off_b,
  output logic [SW-1:0] res_diff,
  output logic          err
);
  localparam int STAGES_EFF = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
  localparam int SETTLE_EFF = (SETTLE_CYC < STAGES_EFF) ? STAGES_EFF : SETTLE_CYC;

  logic                   clear, sample_en, finish;
  logic [NUM_DOMAINS-1:0] raw_lv, sync_lv, found;
  logic [SW-1:0]          off_w [NUM_DOMAINS];

  assign raw_lv = {tgt_b, tgt_a};

  phsk_sweep_ctrl #(
    .STEPS      (STEPS),
    .SETTLE_CYC (SETTLE_EFF)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .step_done   (step_done),
    .step_req_o  (step_req),
    .cur_step_o  (cur_step),
    .clear_o     (clear),
    .sample_en_o (sample_en),
    .finish_o    (finish)
  );

  generate
    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_dom
      phsk_sync #(.STAGES(STAGES_EFF)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lv[g]),
        .q     (sync_lv[g])
      );
      phsk_edge_find #(.SW(SW)) find_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .sample_en (sample_en),
        .level     (sync_lv[g]),
        .step      (cur_step),
        .found_o   (found[g]),
        .offset_o  (off_w[g])
      );
    end
  endgenerate

  logic          both_found;
  logic          valid_d, valid_q;
  logic          err_d, err_q;
  logic [SW-1:0] diff_w;
  logic [SW-1:0] off_a_q, off_b_q, diff_q;

  assign both_found = &found;
  assign diff_w = (off_w[0] >= off_w[1]) ? (off_w[0] - off_w[1]) : (off_w[1] - off_w[0]);

  always_comb begin
    valid_d = finish && both_found;
    err_d   = err_q;
    if (clear)                     err_d = 1'b0;
    else if (finish && !both_found) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      off_a_q <= '0;
      off_b_q <= '0;
      diff_q  <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (valid_d) begin
        off_a_q <= off_w[0];
        off_b_q <= off_w[1];
        diff_q  <= diff_w;
      end
    end
  end

  assign res_valid = valid_q;
  assign err       = err_q;
  assign res_off_a = off_a_q;
  assign res_off_b = off_b_q;
  assign res_diff  = diff_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !err);

  // R7
  err_hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($stable(res_off_a) && $stable(res_off_b) && $stable(res_diff)));
endmodule

// File: tb/phase_skew_meter_tb_top.sv
`timescale 1ns/1ps
module phase_skew_meter_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pll_done = 1'b0;
  logic       stray_done = 1'b0;
  logic [7:0] mask_a = 8'h0F;
  logic [7:0] mask_b = 8'h0F;
  logic [2:0] mstep = 3'd0;
  int         pll_cnt = 0;
  int         pll_lat = 1;
  int         n_done = 0;
  int         n_req_bad = 0;
  int         total = 0;
  int         bad = 0;
  int         last_a = 0;
  int         last_b = 0;

  logic       step_req, res_valid, err;
  logic [2:0] cur_step, res_off_a, res_off_b, res_diff;
  logic       tgt_a, tgt_b;

  always #10 clk = ~clk;

  assign tgt_a = mask_a[mstep];
  assign tgt_b = mask_b[mstep];

  phase_skew_meter #(
    .STEPS       (N),
    .SYNC_STAGES (2),
    .SETTLE_CYC  (3)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_done (pll_done | stray_done),
    .tgt_a     (tgt_a),
    .tgt_b     (tgt_b),
    .step_req  (step_req),
    .cur_step  (cur_step),
    .res_valid (res_valid),
    .res_off_a (res_off_a),
    .res_off_b (res_off_b),
    .res_diff  (res_diff),
    .err       (err)
  );

  // PLL model: shifts phase (changing target levels) and acknowledges
  always @(negedge clk) begin
    if (!rst_n) begin
      pll_cnt  = 0;
      pll_done = 1'b0;
      mstep    = 3'd0;
    end else begin
      pll_done = 1'b0;
      if (pll_cnt != 0) begin
        if (step_req) n_req_bad++;
        pll_cnt--;
        if (pll_cnt == 0) begin
          mstep    = mstep + 3'd1;
          pll_done = 1'b1;
          n_done++;
        end
      end else if (step_req) begin
        pll_cnt = pll_lat;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] half_mask(input int o);
    logic [7:0] m;
    for (int s = 0; s < N; s++) m[s] = (((s - o + N) % N) < N / 2);
    return m;
  endfunction

  function automatic int first_edge(input logic [7:0] m);
    for (int k = 1; k <= N; k++) begin
      if (!m[k - 1] && m[k % N]) return k % N;
    end
    return -1;
  endfunction

  task automatic run(input logic [7:0] ma, input logic [7:0] mb, input int lat,
                     input bit mid, input string tag);
    int ea, eb, w, d;
    mask_a  = ma;
    mask_b  = mb;
    pll_lat = lat;
    n_done  = 0;
    ea = first_edge(ma);
    eb = first_edge(mb);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!res_valid && !err && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (ea >= 0 && eb >= 0) begin
      d = (ea > eb) ? ea - eb : eb - ea;
      chk(res_valid == 1'b1, {tag, " R6 valid"}, int'(res_valid), 1);
      chk(err == 1'b0, {tag, " R7 err clear"}, int'(err), 0);
      chk(int'(res_off_a) == ea, {tag, " R5 off_a"}, int'(res_off_a), ea);
      chk(int'(res_off_b) == eb, {tag, " R5 off_b"}, int'(res_off_b), eb);
      chk(int'(res_diff) == d, {tag, " R6 diff"}, int'(res_diff), d);
      last_a = ea;
      last_b = eb;
      @(negedge clk);
      chk(res_valid == 1'b0, {tag, " R6 one pulse"}, int'(res_valid), 0);
    end else begin
      chk(err == 1'b1, {tag, " R7 err set"}, int'(err), 1);
      chk(res_valid == 1'b0, {tag, " R7 no valid"}, int'(res_valid), 0);
      chk(int'(res_off_a) == last_a, {tag, " R7 hold a"}, int'(res_off_a), last_a);
      chk(int'(res_off_b) == last_b, {tag, " R7 hold b"}, int'(res_off_b), last_b);
      repeat (3) @(negedge clk);
      chk(err == 1'b1, {tag, " R7 err sticky"}, int'(err), 1);
    end
    chk(int'(cur_step) == 0, {tag, " R3 back to start"}, int'(cur_step), 0);
    chk(n_done == N, {tag, " R3 steps per sweep"}, n_done, N);
    chk(n_req_bad == 0, {tag, " R2 req while pending"}, n_req_bad, 0);
  endtask

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(step_req == 1'b0, "R1 step_req", int'(step_req), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(err == 1'b0, "R1 err", int'(err), 0);
    chk(cur_step == 3'd0, "R1 cur_step", int'(cur_step), 0);
    chk(res_diff == 3'd0 && res_off_a == 3'd0 && res_off_b == 3'd0,
        "R1 results", int'(res_diff), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: acknowledge in the very next cycle, levels change at the acknowledge
    run(half_mask(3), half_mask(6), 1, 1'b0, "R4 fast ack");

    // exhaustive offset pairs
    for (int oa = 0; oa < N; oa++) begin
      for (int ob = 0; ob < N; ob++) begin
        run(half_mask(oa), half_mask(ob), 1 + ((oa + ob) % 4), 1'b0, "sweep");
      end
    end

    // R5: two rising edges; the earlier one in sweep order wins
    run(8'b0010_0100, 8'b0010_0001, 2, 1'b0, "R5 double edge");
    run(8'b1000_0001, 8'b0000_0001, 3, 1'b0, "R5 wrap edge");

    // R7: constant targets
    run(8'h00, half_mask(3), 2, 1'b0, "R7 a stuck low");
    run(half_mask(2), 8'hFF, 1, 1'b0, "R7 b stuck high");
    run(half_mask(1), half_mask(4), 2, 1'b0, "R7 recover");

    // R8: second start in mid-sweep
    run(half_mask(5), half_mask(1), 2, 1'b1, "R8 mid start");

    // R2: stray acknowledge while idle
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(cur_step == 3'd0, "R2 stray done ignored", int'(cur_step), 0);
    chk(step_req == 1'b0, "R2 no request idle", int'(step_req), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule